// File: doc/BRIEF.md
# Logarithmic Integer Motion Search

This block finds an integer-pixel motion vector for one 16x16 macroblock. It compares the macroblock against two reference windows using a coarse-to-fine step-halving search. The current macroblock and both reference windows sit in a memory outside the block. The block reads that memory through a single 32-bit port, and each access returns four 8-bit pixels. A caller starts the search with a one-cycle `start` pulse. The block then buffers the current macroblock internally and walks the candidate pattern for reference 0 and then for reference 1. For each candidate it scores 256 absolute pixel differences. At the end it pulses `done` and presents the best vector, the reference it came from and its cost.

Each reference window is 32x32 pixels, that is BLK + 2*HR with BLK=16 and HR=8. Vector (0,0) places the macroblock at window pixel (8,8). A vector may move at most 8 pixels in either axis.

The search for each reference starts at the centre (0,0) with step 8, which is a quarter of the window width. Each step tests the eight neighbours at the current step distance and moves the centre to the cheapest point seen. The step then halves, and the search ends after step 1 has been evaluated.

The controller states are:
- IDLE: wait for `start`.
- LOAD: fetch the current macroblock.
- LDRAIN: take the last returned word.
- CAND: form the candidate and test whether it lies inside the window.
- READ: fetch the candidate's 64 words.
- DRAIN: accumulate the last word.
- CMP: compare the candidate's cost with the best so far.
- ADV: move to the next candidate, or finish the step and halve it.
- REFEND: merge the result for the current reference into the overall result.
- DONE: pulse `done`.

The transitions are:
- IDLE to LOAD when `start` is high.
- LOAD to LDRAIN after 64 reads.
- LDRAIN to CAND.
- CAND to READ for an in-window candidate, or CAND to ADV for one outside the window.
- READ to DRAIN after 64 reads.
- DRAIN to CMP.
- CMP to ADV.
- ADV to CAND, or ADV to REFEND after the eighth neighbour at step 1.
- REFEND to CAND to begin reference 1, or REFEND to DONE after reference 1.
- DONE to IDLE.

Top module: `me_log_search`

## Requirements
- R1: After reset, `done` and `rd_en` are 0, and `mv_x`, `mv_y`, `ref_idx` and `sad` are 0.
- R2: A `start` pulse in IDLE issues 64 consecutive reads with `rd_sel`=0 (current block). Word k is read at x=4*(k mod 4), y=k/4. Read data returns on the cycle after `rd_en`, and byte lane j (bits 8j+7:8j) holds pixel x+j.
- R3: Candidate (mx,my) of reference r is fetched with `rd_sel`=1+r. It takes 64 reads, with word k at x=8+mx+4*(k mod 4), y=8+my+k/4. Every read address stays inside the window (x at most 28, y at most 31).
- R4: A candidate's cost is the sum over all 256 pixels of |current - reference|. It is held in 16 bits, and its largest value is 65280, which does not wrap.
- R5: Each reference is searched from centre (0,0) with step 8. The centre is evaluated first. Its neighbours follow in raster order (dy -1..1 outer, dx -1..1 inner, centre excluded). At the end of each step the centre moves to the best point and the step halves, until step 1 is done.
- R6: A candidate with |mx|>8 or |my|>8 is skipped and issues no reads. One search issues exactly 64*(1 + in-window candidates) reads.
- R7: On equal cost the earlier candidate is kept, and reference 0 is kept over reference 1.
- R8: The reported result is the lowest-cost vector over both references, together with its reference index and cost.
- R9: `done` is high for exactly one cycle, with the results valid in that cycle. The results stay unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (taken in IDLE) |
| rd_en | output | 1 | Read request |
| rd_sel | output | 2 | Read target: 0 current block, 1 reference 0, 2 reference 1 |
| rd_x | output | 5 | Pixel column of the first of four pixels |
| rd_y | output | 5 | Pixel row |
| rd_data | input | 32 | Four pixels, returned one cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| mv_x | output | 7 | Best horizontal vector, signed |
| mv_y | output | 7 | Best vertical vector, signed |
| ref_idx | output | 1 | Reference holding the best vector |
| sad | output | 16 | Cost of the best vector |

## Verification
The memory model answers each read on the clock edge after `rd_en`, and the final costs, vector and reference are due in the same cycle in which `done` is high. The bench drives `start` and samples every output on falling clock edges. After a start it polls `done` on each falling edge and compares the results at the first falling edge where `done` is high. It checks that `done` has dropped one falling edge later, and that the results are unchanged twenty cycles after that. The read count is the number of `rd_en` cycles from start to `done`, and it is compared against the count that the bench's own search model predicts.

// File: rtl/me_pkg.sv
package me_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_LDRAIN,
        S_CAND,
        S_READ,
        S_DRAIN,
        S_CMP,
        S_ADV,
        S_REFEND,
        S_DONE
    } me_state_t;

    localparam logic [1:0] SEL_CUR  = 2'd0;
    localparam logic [1:0] SEL_REF0 = 2'd1;

    localparam int LANES  = 4;
    localparam int PIXW   = 8;
    localparam int NEIGHB = 8;

endpackage

// File: rtl/me_cur_store.sv
module me_cur_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/me_sad_acc.sv
module me_sad_acc import me_pkg::*; #(
    parameter int SADW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  vld,
    input  logic [LANES*PIXW-1:0] cur_w,
    input  logic [LANES*PIXW-1:0] ref_w,
    output logic [SADW-1:0]       acc
);
    localparam int SUMW = PIXW + $clog2(LANES);

    logic [PIXW-1:0] diff [LANES];
    logic [SUMW-1:0] word_sum;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PIXW-1:0] a, b;
        assign a = cur_w[g*PIXW +: PIXW];
        assign b = ref_w[g*PIXW +: PIXW];
        assign diff[g] = (a > b) ? (a - b) : (b - a);
    end

    always_comb begin
        word_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            word_sum = word_sum + SUMW'(diff[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (vld) begin
            acc <= acc + SADW'(word_sum);
        end
    end
endmodule

// File: rtl/me_cand_gen.sv
module me_cand_gen #(
    parameter int MVW = 7,
    parameter int SW  = 5,
    parameter int HR  = 8
) (
    input  logic signed [MVW-1:0] ctr_x,
    input  logic signed [MVW-1:0] ctr_y,
    input  logic        [SW-1:0]  step,
    input  logic        [3:0]     cidx,
    output logic signed [MVW-1:0] cand_x,
    output logic signed [MVW-1:0] cand_y,
    output logic                  inwin
);
    int pos, dx, dy, cx, cy;

    always_comb begin
        if (cidx == 4'd0) begin
            pos = 4;
        end else if (cidx <= 4'd4) begin
            pos = int'(cidx) - 1;
        end else begin
            pos = int'(cidx);
        end
        dx = (pos % 3) - 1;
        dy = (pos / 3) - 1;
        cx = int'(ctr_x) + dx * int'(step);
        cy = int'(ctr_y) + dy * int'(step);
        cand_x = MVW'(cx);
        cand_y = MVW'(cy);
        inwin = (cx >= -HR) && (cx <= HR) && (cy >= -HR) && (cy <= HR);
    end
endmodule

// File: rtl/me_log_search.sv
module me_log_search import me_pkg::*; #(
    parameter int  BLK  = 16,
    parameter int  HR   = 8,
    localparam int W    = BLK + 2*HR,
    localparam int CW   = $clog2(W),
    localparam int MVW  = CW + 2,
    localparam int SADW = $clog2(255*BLK*BLK + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  rd_en,
    output logic [1:0]            rd_sel,
    output logic [CW-1:0]         rd_x,
    output logic [CW-1:0]         rd_y,
    input  logic [31:0]           rd_data,
    output logic                  done,
    output logic signed [MVW-1:0] mv_x,
    output logic signed [MVW-1:0] mv_y,
    output logic                  ref_idx,
    output logic [SADW-1:0]       sad
);
    localparam int NW    = BLK*BLK/LANES;
    localparam int CNTW  = $clog2(NW);
    localparam int WPR   = BLK/LANES;
    localparam int STEP0 = W/4;

    me_state_t state, nxt;

    logic [CNTW-1:0]       cnt, didx;
    logic                  dvld_ld, dvld_sad;
    logic                  ref_i;
    logic [CW-1:0]         step;
    logic [3:0]            cidx;
    logic signed [MVW-1:0] ctr_x, ctr_y;
    logic signed [MVW-1:0] cand_x, cand_y;
    logic                  inwin;
    logic [SADW-1:0]       rb_sad;
    logic signed [MVW-1:0] rb_x, rb_y;
    logic [SADW-1:0]       acc;
    logic [31:0]           cur_w;
    logic                  sad_clr;

    me_cand_gen #(.MVW(MVW), .SW(CW), .HR(HR)) u_cand (
        .ctr_x(ctr_x), .ctr_y(ctr_y), .step(step), .cidx(cidx),
        .cand_x(cand_x), .cand_y(cand_y), .inwin(inwin)
    );

    me_cur_store #(.DEPTH(NW), .DW(32)) u_store (
        .clk(clk), .we(dvld_ld), .waddr(didx), .wdata(rd_data),
        .raddr(didx), .rdata(cur_w)
    );

    me_sad_acc #(.SADW(SADW)) u_sad (
        .clk(clk), .rst_n(rst_n), .clr(sad_clr), .vld(dvld_sad),
        .cur_w(cur_w), .ref_w(rd_data), .acc(acc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_LOAD;
            S_LOAD:   if (cnt == CNTW'(NW-1)) nxt = S_LDRAIN;
            S_LDRAIN: nxt = S_CAND;
            S_CAND:   nxt = inwin ? S_READ : S_ADV;
            S_READ:   if (cnt == CNTW'(NW-1)) nxt = S_DRAIN;
            S_DRAIN:  nxt = S_CMP;
            S_CMP:    nxt = S_ADV;
            S_ADV:    nxt = (cidx == 4'(NEIGHB) && step == CW'(1)) ? S_REFEND : S_CAND;
            S_REFEND: nxt = ref_i ? S_DONE : S_CAND;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        int ci, ri;
        ci = int'(cnt) % WPR;
        ri = int'(cnt) / WPR;
        rd_en   = 1'b0;
        rd_sel  = SEL_CUR;
        rd_x    = '0;
        rd_y    = '0;
        done    = 1'b0;
        sad_clr = 1'b0;
        unique case (state)
            S_LOAD: begin
                rd_en = 1'b1;
                rd_x  = CW'(ci*LANES);
                rd_y  = CW'(ri);
            end
            S_READ: begin
                rd_en  = 1'b1;
                rd_sel = SEL_REF0 + 2'(ref_i);
                rd_x   = CW'(HR + int'(cand_x) + ci*LANES);
                rd_y   = CW'(HR + int'(cand_y) + ri);
            end
            S_CAND: sad_clr = 1'b1;
            S_DONE: done    = 1'b1;
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            didx     <= '0;
            dvld_ld  <= 1'b0;
            dvld_sad <= 1'b0;
            ref_i    <= 1'b0;
            step     <= CW'(STEP0);
            cidx     <= '0;
            ctr_x    <= '0;
            ctr_y    <= '0;
            rb_sad   <= '1;
            rb_x     <= '0;
            rb_y     <= '0;
            mv_x     <= '0;
            mv_y     <= '0;
            ref_idx  <= 1'b0;
            sad      <= '0;
        end else begin
            dvld_ld  <= (state == S_LOAD);
            dvld_sad <= (state == S_READ);
            didx     <= cnt;
            unique case (state)
                S_IDLE: cnt <= '0;
                S_LOAD, S_READ: cnt <= cnt + 1'b1;
                S_LDRAIN: begin
                    ref_i  <= 1'b0;
                    ctr_x  <= '0;
                    ctr_y  <= '0;
                    step   <= CW'(STEP0);
                    cidx   <= '0;
                    rb_sad <= '1;
                end
                S_CAND: cnt <= '0;
                S_CMP: begin
                    if (acc < rb_sad) begin
                        rb_sad <= acc;
                        rb_x   <= cand_x;
                        rb_y   <= cand_y;
                    end
                end
                S_ADV: begin
                    if (cidx == 4'(NEIGHB)) begin
                        ctr_x <= rb_x;
                        ctr_y <= rb_y;
                        step  <= step >> 1;
                        cidx  <= 4'd1;
                    end else begin
                        cidx <= cidx + 4'd1;
                    end
                end
                S_REFEND: begin
                    if (!ref_i || rb_sad < sad) begin
                        mv_x    <= rb_x;
                        mv_y    <= rb_y;
                        ref_idx <= ref_i;
                        sad     <= rb_sad;
                    end
                    ref_i  <= 1'b1;
                    ctr_x  <= '0;
                    ctr_y  <= '0;
                    step   <= CW'(STEP0);
                    cidx   <= '0;
                    rb_sad <= '1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/me_log_search_chk.sv
module me_log_search_chk #(
    parameter int  BLK  = 16,
    parameter int  HR   = 8,
    localparam int W    = BLK + 2*HR,
    localparam int CW   = $clog2(W),
    localparam int MVW  = CW + 2,
    localparam int SADW = $clog2(255*BLK*BLK + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  rd_en,
    input logic [1:0]            rd_sel,
    input logic [CW-1:0]         rd_x,
    input logic [CW-1:0]         rd_y,
    input logic                  done,
    input logic signed [MVW-1:0] mv_x,
    input logic signed [MVW-1:0] mv_y,
    input logic                  ref_idx,
    input logic [SADW-1:0]       sad
);
    logic held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (start) begin
            held <= 1'b0;
        end else if (done) begin
            held <= 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !start) |=> ($stable(mv_x) && $stable(mv_y) && $stable(ref_idx) && $stable(sad))); // R9
    AST_RD_X_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_x) <= W - 4)); // R3
    AST_RD_Y_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_y) <= W - 1)); // R3
    AST_RD_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_sel != 2'd3)); // R3
    AST_MV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(mv_x) >= -HR && int'(mv_x) <= HR && int'(mv_y) >= -HR && int'(mv_y) <= HR)); // R6
    AST_SAD_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(sad) <= 255*BLK*BLK)); // R4
    AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en); // R2
endmodule

bind me_log_search me_log_search_chk #(.BLK(BLK), .HR(HR)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_x(rd_x), .rd_y(rd_y), .done(done), .mv_x(mv_x), .mv_y(mv_y),
    .ref_idx(ref_idx), .sad(sad)
);

// File: tb/test_me_log_search.sv
`timescale 1ns/1ps
module test_me_log_search;
    localparam int BLK = 16;
    localparam int HR  = 8;
    localparam int W   = BLK + 2*HR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [1:0]  rd_sel;
    logic [4:0]  rd_x, rd_y;
    logic [31:0] rd_data = '0;
    logic        done;
    logic signed [6:0] mv_x, mv_y;
    logic        ref_idx;
    logic [15:0] sad;

    int checks = 0;
    int fails  = 0;
    int nread  = 0;
    int nbad   = 0;

    logic [7:0] curm [BLK][BLK];
    logic [7:0] refm [2][W][W];

    always #4 clk = ~clk;

    me_log_search i_me_log_search (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_x(rd_x), .rd_y(rd_y), .rd_data(rd_data), .done(done),
        .mv_x(mv_x), .mv_y(mv_y), .ref_idx(ref_idx), .sad(sad)
    );

    // memory model: one-cycle read latency, lane j = pixel x+j (R2, R3)
    always @(posedge clk) begin
        if (rd_en) begin
            int x, y;
            logic [31:0] w;
            x = int'(rd_x);
            y = int'(rd_y);
            nread++;
            w = '0;
            if (rd_sel == 2'd0) begin
                if (x > BLK-4 || y > BLK-1 || (x % 4) != 0) nbad++;
                else for (int j = 0; j < 4; j++) w[8*j +: 8] = curm[y][x+j];
            end else if (rd_sel == 2'd1 || rd_sel == 2'd2) begin
                if (x > W-4 || y > W-1) nbad++;
                else for (int j = 0; j < 4; j++) w[8*j +: 8] = refm[int'(rd_sel)-1][y][x+j];
            end else begin
                nbad++;
            end
            rd_data <= w;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sad_of(input int r, input int mx, input int my);
        int s = 0;
        for (int y = 0; y < BLK; y++)
            for (int x = 0; x < BLK; x++) begin
                int a, b;
                a = int'(curm[y][x]);
                b = int'(refm[r][HR+my+y][HR+mx+x]);
                s += (a > b) ? a - b : b - a;
            end
        return s;
    endfunction

    // independent model of the search (R5, R6, R7, R8)
    task automatic model(output int ex, output int ey, output int er, output int es, output int ecnt);
        ecnt = 1;
        es = 0; ex = 0; ey = 0; er = 0;
        for (int r = 0; r < 2; r++) begin
            int cx, cy, st, bs, bx, by;
            cx = 0; cy = 0; st = W/4;
            bs = sad_of(r, 0, 0); bx = 0; by = 0;
            ecnt++;
            while (st >= 1) begin
                for (int k = 0; k < 9; k++) begin
                    int px, py;
                    if (k == 4) continue;
                    px = cx + (k % 3 - 1) * st;
                    py = cy + (k / 3 - 1) * st;
                    if (px < -HR || px > HR || py < -HR || py > HR) continue;
                    ecnt++;
                    begin
                        int s;
                        s = sad_of(r, px, py);
                        if (s < bs) begin bs = s; bx = px; by = py; end
                    end
                end
                cx = bx; cy = by; st = st / 2;
            end
            if (r == 0 || bs < es) begin es = bs; ex = bx; ey = by; er = r; end
        end
        ecnt = ecnt * 64;
    endtask

    task automatic run_case(input string name);
        int ex, ey, er, es, ecnt, n0, b0, waited;
        logic signed [6:0] hx, hy;
        logic hr;
        logic [15:0] hs;
        model(ex, ey, er, es, ecnt);
        n0 = nread; b0 = nbad;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done === 1'b1, {"R9 done seen ", name}, int'(done), 1);
        chk(int'(mv_x) == ex, {"R5 R8 mv_x ", name}, int'(mv_x), ex);
        chk(int'(mv_y) == ey, {"R5 R8 mv_y ", name}, int'(mv_y), ey);
        chk(int'(ref_idx) == er, {"R7 R8 ref_idx ", name}, int'(ref_idx), er);
        chk(int'(sad) == es, {"R4 R8 sad ", name}, int'(sad), es);
        chk(nread - n0 == ecnt, {"R2 R6 read count ", name}, nread - n0, ecnt);
        chk(nbad == b0, {"R3 address bounds ", name}, nbad - b0, 0);
        hx = mv_x; hy = mv_y; hr = ref_idx; hs = sad;
        @(negedge clk);
        chk(done == 1'b0, {"R9 done one cycle ", name}, int'(done), 0);
        repeat (20) @(negedge clk);
        chk(mv_x == hx && mv_y == hy && ref_idx == hr && sad == hs,
            {"R9 results held ", name}, int'(sad), int'(hs));
    endtask

    task automatic fill_const(input int c, input int rv);
        for (int y = 0; y < BLK; y++) for (int x = 0; x < BLK; x++) curm[y][x] = 8'(c);
        for (int r = 0; r < 2; r++) for (int y = 0; y < W; y++) for (int x = 0; x < W; x++)
            refm[r][y][x] = 8'(rv);
    endtask

    task automatic fill_rand();
        for (int y = 0; y < BLK; y++) for (int x = 0; x < BLK; x++) curm[y][x] = 8'($urandom);
        for (int r = 0; r < 2; r++) for (int y = 0; y < W; y++) for (int x = 0; x < W; x++)
            refm[r][y][x] = 8'($urandom);
    endtask

    task automatic fill_grad(input int sx, input int sy, input int tgt);
        for (int r = 0; r < 2; r++) for (int y = 0; y < W; y++) for (int x = 0; x < W; x++)
            refm[r][y][x] = 8'(3*x + 5*y);
        for (int y = 0; y < BLK; y++) for (int x = 0; x < BLK; x++)
            curm[y][x] = refm[tgt][HR+sy+y][HR+sx+x];
        for (int y = 0; y < W; y++) for (int x = 0; x < W; x++)
            refm[1-tgt][y][x] = 8'(3*x + 5*y + 7);
    endtask

    task automatic plant(input int sx, input int sy, input int tgt);
        fill_rand();
        for (int y = 0; y < BLK; y++) for (int x = 0; x < BLK; x++)
            refm[tgt][HR+sy+y][HR+sx+x] = curm[y][x];
    endtask

    initial begin
        void'($urandom(17));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0 && rd_en == 1'b0, "R1 reset done/rd_en", int'(done) + int'(rd_en), 0);
        chk(mv_x == 0 && mv_y == 0 && ref_idx == 0 && sad == 0, "R1 reset results", int'(sad), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(rd_en == 1'b0 && done == 1'b0, "R1 idle after reset", int'(rd_en), 0);

        fill_const(50, 50);   run_case("flat ties R7");
        fill_const(255, 0);   run_case("max cost R4");
        fill_grad(5, 3, 0);   run_case("gradient ref0");
        fill_grad(8, 8, 1);   run_case("corner skip R6");
        fill_grad(-8, -7, 0); run_case("neg corner R6");
        fill_grad(-3, 6, 1);  run_case("gradient ref1");
        plant(0, 0, 1);       run_case("planted centre ref1");
        plant(8, 0, 0);       run_case("planted step8");
        fill_rand();          run_case("random a");
        fill_rand();          run_case("random b");
        fill_rand();
        for (int y = 0; y < W; y++) for (int x = 0; x < W; x++) refm[1][y][x] = refm[0][y][x];
        run_case("equal refs R7");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule